// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 64 interrupt request lines, brings each through a two-stage synchroniser, and turns them into a single registered interrupt request for a processor. Every source has its own detection mode, which is a low or high level or a falling or rising edge. Every source also has its own priority. A priority of zero switches the source off. A global threshold passes only sources whose priority is strictly above it, and a global enable gates the output.

Among the eligible pending sources, the controller picks the one with the highest priority. On a tie, the lowest source number wins. The controller reports the chosen source through a status word that the processor reads over a simple register bus (address, write data, write strobe and combinational read data). Edge-mode sources hold a latch. The latch stays set until software writes an indexed clear command, so the handler acknowledges one edge source at a time. Source number 0 is reserved and is never reported.

Register word addresses:
- 0: control. Bit 0 is the global enable.
- 1: threshold. The full priority width.
- 2: status. Read only.
- 4 and 5: edge-clear command words, for sources 0..31 and 32..63.
- 8 to 11: mode words. Each word holds 16 two-bit fields, and source s sits at bits 2*(s%16)+1:2*(s%16) of word 8+s/16.
- 16 to 31: priority words. Each word holds four byte-wide fields, and source s sits at bits 8*(s%4)+7:8*(s%4) of word 16+s/4.

Top module: `irqc_top`

## Requirements
- R1: After reset the interrupt output is low, the status word reads 0x00010000, and the control, threshold, mode and priority words all read zero.
- R2: Mode code 0 makes a source pending while its input is low, and mode code 1 makes it pending while its input is high. A level source stops being pending as soon as the input returns to its inactive value.
- R3: Mode code 3 latches a rising edge and mode code 2 latches a falling edge. An edge source stays pending after its input returns, and an edge of the opposite direction sets nothing.
- R4: An edge latch is cleared by a write to word 4 (sources 0..31) or word 5 (sources 32..63). Within each 16-bit half of the write data, bit 8 is the clear enable and bits 3:0 give the index. The lower half addresses the first 16 sources of that word's range and the upper half (data bits 24 and 19:16) addresses the next 16. A write without the enable bit, or with another index, leaves the latch set.
- R5: A priority field of 0 keeps its source from being selected. Priority fields read back at their packed positions.
- R6: A pending source is eligible only when its priority is strictly greater than the threshold word.
- R7: While control bit 0 is clear, the interrupt output stays low and the status word reads 0x00010000.
- R8: The selected source is the eligible source with the highest priority. Among equal priorities, the lowest source number is selected.
- R9: Status bit 16 is set when no source is selected. Otherwise it is clear and bits 5:0 hold the selected source number.
- R10: Source 0 is never selected, whatever its mode, priority and input.
- R11: A write to a priority, threshold or control word changes the interrupt output at the clock edge after the write edge.
- R12: A change at a source input reaches the interrupt output through two synchroniser stages. For a level source, the output changes at the third rising edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Asynchronous interrupt request inputs, bit n is source n |
| addr_i | input | 6 | Register word address |
| wdata_i | input | 32 | Register write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
On every cycle, the embedded properties check the following:
- the output rises only after the enable was set;
- a reported index is never zero;
- the selector's choice is pending and lies above the threshold;
- a clear command without a coincident edge empties the latch.

The tie-break order, the mode encodings, the exact latency of the synchroniser and of register writes, and the handling of malformed clear commands can only be shown by the bench's directed scenarios, which compare the status word against values derived from the register layout.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W      = 32;
    localparam int MODE_PER_W  = 16;
    localparam int PRIO_PER_W  = 4;
    localparam int PRIO_STRIDE = 8;
    localparam int CLR_PER_W   = 32;
    localparam int CLR_HALF    = 16;
    localparam int NONE_BIT    = 16;
    localparam int CLR_EN_BIT  = 8;

    localparam int ADR_CTRL    = 0;
    localparam int ADR_THRESH  = 1;
    localparam int ADR_STATUS  = 2;
    localparam int ADR_CLR     = 4;
    localparam int ADR_MODE    = 8;
    localparam int ADR_PRIO    = 16;

    typedef enum logic [1:0] {
        MODE_LVL_LO   = 2'd0,
        MODE_LVL_HI   = 2'd1,
        MODE_EDGE_FAL = 2'd2,
        MODE_EDGE_RIS = 2'd3
    } det_mode_e;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 64,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= d_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
    import irqc_pkg::*;
#(
    parameter int N = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       sig_i,
    input  logic [N-1:0][1:0]  mode_i,
    input  logic [N-1:0]       clr_i,
    output logic [N-1:0]       pend_o
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_src
            logic prev_q;
            logic latch_q;
            logic hit;
            logic level_act;

            always_comb begin
                hit       = 1'b0;
                level_act = 1'b0;
                unique case (det_mode_e'(mode_i[i]))
                    MODE_LVL_LO:   level_act = !sig_i[i];
                    MODE_LVL_HI:   level_act = sig_i[i];
                    MODE_EDGE_FAL: hit = prev_q && !sig_i[i];
                    MODE_EDGE_RIS: hit = !prev_q && sig_i[i];
                    default:       hit = 1'b0;
                endcase
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q  <= 1'b0;
                    latch_q <= 1'b0;
                end else begin
                    prev_q <= sig_i[i];
                    if (!mode_i[i][1]) begin
                        latch_q <= 1'b0;
                    end else if (hit) begin
                        latch_q <= 1'b1;
                    end else if (clr_i[i]) begin
                        latch_q <= 1'b0;
                    end
                end
            end

            assign pend_o[i] = (i != 0) && (mode_i[i][1] ? latch_q : level_act);

            // R4
            edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i[i][1] && clr_i[i] && !hit) |=> !latch_q);
        end
    endgenerate

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter  int N  = 64,
    parameter  int PW = 8,
    localparam int IW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        pend_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    input  logic [PW-1:0]       thresh_i,
    output logic                valid_o,
    output logic [IW-1:0]       idx_o
);

    logic [N-1:0]  elig;
    logic [PW-1:0] best;

    always_comb begin
        elig    = '0;
        best    = '0;
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < N; i++) begin
            elig[i] = pend_i[i] && (prio_i[i] != '0) && (prio_i[i] > thresh_i);
        end
        // scan downwards; ">=" lets a lower index take over a tie
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i] && (!valid_o || prio_i[i] >= best)) begin
                valid_o = 1'b1;
                best    = prio_i[i];
                idx_o   = i[IW-1:0];
            end
        end
    end

    // R8
    win_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> pend_i[idx_o]);

    // R6
    win_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (prio_i[idx_o] > thresh_i));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter  int NUM_SRC = 64,
    parameter  int PRIO_W  = 8,
    parameter  int ADDR_W  = 6,
    parameter  int SYNC_N  = 2,
    localparam int IDX_W   = $clog2(NUM_SRC),
    localparam int N_MODE  = NUM_SRC / MODE_PER_W,
    localparam int N_PRIO  = NUM_SRC / PRIO_PER_W,
    localparam int N_CLR   = NUM_SRC / CLR_PER_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    logic                            en_q;
    logic [PRIO_W-1:0]               thresh_q;
    logic [NUM_SRC-1:0][1:0]         mode_q;
    logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q;
    logic                            irq_q;
    logic                            none_q;
    logic [IDX_W-1:0]                idx_q;

    logic [NUM_SRC-1:0] sig;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] pend;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic               fire;
    int                 adr;

    assign adr = int'(addr_i);

    irqc_sync #(.W(NUM_SRC), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_i),
        .q_o   (sig)
    );

    irqc_detect #(.N(NUM_SRC)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sig),
        .mode_i (mode_q),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irqc_arbiter #(.N(NUM_SRC), .PW(PRIO_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend),
        .prio_i   (prio_q),
        .thresh_i (thresh_q),
        .valid_o  (win_valid),
        .idx_o    (win_idx)
    );

    // indexed edge-clear commands, two halves per command word
    always_comb begin
        clr = '0;
        for (int r = 0; r < N_CLR; r++) begin
            for (int h = 0; h < 2; h++) begin
                if (we_i && adr == ADR_CLR + r && wdata_i[CLR_HALF*h + CLR_EN_BIT]) begin
                    clr[r*CLR_PER_W + h*CLR_HALF + int'(wdata_i[CLR_HALF*h +: 4])] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            thresh_q <= '0;
            mode_q   <= '0;
            prio_q   <= '0;
        end else if (we_i) begin
            if (adr == ADR_CTRL) en_q <= wdata_i[0];
            if (adr == ADR_THRESH) thresh_q <= wdata_i[PRIO_W-1:0];
            for (int r = 0; r < N_MODE; r++) begin
                if (adr == ADR_MODE + r) begin
                    for (int f = 0; f < MODE_PER_W; f++) begin
                        mode_q[r*MODE_PER_W + f] <= wdata_i[2*f +: 2];
                    end
                end
            end
            for (int r = 0; r < N_PRIO; r++) begin
                if (adr == ADR_PRIO + r) begin
                    for (int f = 0; f < PRIO_PER_W; f++) begin
                        prio_q[r*PRIO_PER_W + f] <= wdata_i[PRIO_STRIDE*f +: PRIO_W];
                    end
                end
            end
        end
    end

    assign fire = en_q && win_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            none_q <= 1'b1;
            idx_q  <= '0;
        end else begin
            irq_q  <= fire;
            none_q <= !fire;
            idx_q  <= fire ? win_idx : '0;
        end
    end

    assign irq_o = irq_q;

    always_comb begin
        rdata_o = '0;
        if (adr == ADR_CTRL)   rdata_o[0] = en_q;
        if (adr == ADR_THRESH) rdata_o[PRIO_W-1:0] = thresh_q;
        if (adr == ADR_STATUS) begin
            rdata_o[NONE_BIT]  = none_q;
            rdata_o[IDX_W-1:0] = idx_q;
        end
        for (int r = 0; r < N_MODE; r++) begin
            if (adr == ADR_MODE + r) begin
                for (int f = 0; f < MODE_PER_W; f++) begin
                    rdata_o[2*f +: 2] = mode_q[r*MODE_PER_W + f];
                end
            end
        end
        for (int r = 0; r < N_PRIO; r++) begin
            if (adr == ADR_PRIO + r) begin
                for (int f = 0; f < PRIO_PER_W; f++) begin
                    rdata_o[PRIO_STRIDE*f +: PRIO_W] = prio_q[r*PRIO_PER_W + f];
                end
            end
        end
    end

    // R7
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(en_q));

    // R10
    stat_idx_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !none_q |-> (idx_q != '0));

endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] NONE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '1;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [1:0] sh_mode [64];
    logic [7:0] sh_prio [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src),
        .addr_i  (addr),
        .wdata_i (wdata),
        .we_i    (we),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr  = 6'(a);
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = 6'(a);
        #1;
        d = rdata;
    endtask

    task automatic check_status(input string req, input logic [31:0] exp);
        logic [31:0] v;
        rd(2, v);
        check(req, v, exp);
    endtask

    task automatic set_mode(input int s, input logic [1:0] m);
        logic [31:0] w;
        sh_mode[s] = m;
        for (int f = 0; f < 16; f++) w[2*f +: 2] = sh_mode[(s/16)*16 + f];
        wr(8 + s/16, w);
    endtask

    task automatic set_prio(input int s, input logic [7:0] p);
        logic [31:0] w;
        sh_prio[s] = p;
        for (int f = 0; f < 4; f++) w[8*f +: 8] = sh_prio[(s/4)*4 + f];
        wr(16 + s/4, w);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 irq", {31'b0, irq}, 32'h0);
        check_status("R1 R9 status", NONE);
        rd(0, v);  check("R1 ctrl", v, 32'h0);
        rd(1, v);  check("R1 thresh", v, 32'h0);
        rd(8, v);  check("R1 mode", v, 32'h0);
        rd(16, v); check("R1 prio", v, 32'h0);
    endtask

    task automatic t_src0;
        wr(0, 32'h1);
        set_mode(0, 2'd1);
        set_prio(0, 8'd7);
        waitc(5);
        check("R10 irq", {31'b0, irq}, 32'h0);
        check_status("R10 status", NONE);
        set_prio(0, 8'd0);
    endtask

    task automatic t_level;
        src[5] = 1'b0;
        set_mode(5, 2'd1);
        set_prio(5, 8'd3);
        waitc(5);
        check("R2 high idle", {31'b0, irq}, 32'h0);
        src[5] = 1'b1;
        waitc(5);
        check("R2 high active", {31'b0, irq}, 32'h1);
        check_status("R2 R9 status", 32'd5);
        src[5] = 1'b0;
        waitc(5);
        check("R2 high released", {31'b0, irq}, 32'h0);
        set_mode(5, 2'd0);
        waitc(2);
        check("R2 low active", {31'b0, irq}, 32'h1);
        check_status("R2 low status", 32'd5);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        set_prio(5, 8'd0);
        waitc(2);
        check("R5 masked", {31'b0, irq}, 32'h0);
        set_prio(7, 8'd5);
        rd(17, v);
        check("R5 field pos", v, 32'h0500_0000);
        set_prio(7, 8'd0);
    endtask

    task automatic t_timing;
        set_prio(5, 8'd3);
        check("R11 before", {31'b0, irq}, 32'h0);
        waitc(1);
        check("R11 after", {31'b0, irq}, 32'h1);
        src[5] = 1'b1;
        waitc(2);
        check("R12 two edges", {31'b0, irq}, 32'h1);
        waitc(1);
        check("R12 third edge", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_thresh;
        src[5] = 1'b0;
        waitc(5);
        check("R6 base", {31'b0, irq}, 32'h1);
        wr(1, 32'd3);
        waitc(2);
        check("R6 equal", {31'b0, irq}, 32'h0);
        wr(1, 32'd2);
        waitc(2);
        check("R6 above", {31'b0, irq}, 32'h1);
        check_status("R6 status", 32'd5);
        wr(1, 32'd0);
    endtask

    task automatic t_enable;
        wr(0, 32'h0);
        waitc(2);
        check("R7 off irq", {31'b0, irq}, 32'h0);
        check_status("R7 off status", NONE);
        wr(0, 32'h1);
        waitc(2);
        check("R7 on irq", {31'b0, irq}, 32'h1);
        src[5] = 1'b1;
        set_prio(5, 8'd0);
        waitc(5);
    endtask

    task automatic t_order;
        set_mode(10, 2'd1);
        set_mode(20, 2'd1);
        set_prio(10, 8'd4);
        set_prio(20, 8'd6);
        waitc(2);
        check_status("R8 higher prio", 32'd20);
        set_mode(7, 2'd1);
        set_prio(7, 8'd6);
        waitc(2);
        check_status("R8 tie lowest", 32'd7);
        set_mode(63, 2'd1);
        set_prio(63, 8'd7);
        waitc(2);
        check_status("R8 top prio", 32'd63);
        set_prio(10, 8'd0);
        set_prio(20, 8'd0);
        set_prio(7, 8'd0);
        set_prio(63, 8'd0);
        waitc(2);
        check_status("R8 cleared", NONE);
    endtask

    task automatic t_edge;
        src[40] = 1'b0;
        set_mode(40, 2'd3);
        set_prio(40, 8'd2);
        waitc(6);
        check("R3 no rise", {31'b0, irq}, 32'h0);
        src[40] = 1'b1;
        waitc(6);
        check("R3 rise", {31'b0, irq}, 32'h1);
        check_status("R3 status", 32'd40);
        src[40] = 1'b0;
        waitc(6);
        check("R3 held", {31'b0, irq}, 32'h1);
        wr(5, 32'h0000_0008);
        waitc(2);
        check("R4 no enable", {31'b0, irq}, 32'h1);
        wr(5, 32'h0000_0109);
        waitc(2);
        check("R4 wrong index", {31'b0, irq}, 32'h1);
        wr(5, 32'h0000_0108);
        waitc(1);
        check("R4 cleared", {31'b0, irq}, 32'h0);
        check_status("R4 status", NONE);
        set_mode(57, 2'd2);
        set_prio(57, 8'd2);
        src[57] = 1'b0;
        waitc(6);
        check_status("R3 fall", 32'd57);
        wr(5, 32'h0109_0000);
        waitc(2);
        check("R4 upper half", {31'b0, irq}, 32'h0);
        check_status("R4 upper status", NONE);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            sh_mode[i] = 2'd0;
            sh_prio[i] = 8'd0;
        end
        waitc(3);
        rst_n = 1'b1;
        waitc(1);
        t_reset();
        t_src0();
        t_level();
        t_mask();
        t_timing();
        t_thresh();
        t_enable();
        t_order();
        t_edge();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule